// File: doc/BRIEF.md
# Single-Row Pixel Copy Engine

The engine sits behind a copy aperture on a 64-bit system bus. One bus write starts a horizontal copy of 1 to 32 pixels inside a linear pixel memory that is 1152 pixels wide per line. The write address gives the destination pixel as a linear index Y*1152+X. The write data gives the source pixel index and the run length. The engine then streams the pixels through its memory port: it reads one source pixel per cycle and writes that pixel to its destination on the following cycle.

A mode input selects what each copy carries. A 24-bit copy moves only the colour bits and leaves the two top bits of each destination pixel as they were. A raw copy moves all 26 bits. Until the last pixel write has been issued, the engine reports busy and holds its ready output low. During that time a bus master's next write waits and is not lost. Source and destination runs may overlap. The engine picks the copy direction so that the result is the same as a copy made from an untouched snapshot of the source run.

Top module: `pixel_row_copier`

## Requirements
- R1: A write is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole time `busy` is high. A write that is presented while busy is held, and it is taken on the first cycle after `busy` falls.
- R2: The destination index is `wr_addr[22:3]`. The source index is `wr_data[19:0]`. The run length is `wr_data[28:24]` plus one, which gives 1 to 32 pixels. Any start pixel is allowed, with no alignment needed.
- R3: A write with `wr_addr[2:0]` not equal to zero is taken, but it starts no copy: `busy` stays low and no memory write is issued.
- R4: The first source read is issued in the cycle after the write is taken, and one read is issued per cycle after that. Each pixel's write is issued one cycle after its read and carries the data returned by that read. For a run of N pixels, `busy` is high for exactly N+1 cycles.
- R5: With `raw_mode` at 0, `pm_wr_mask` is 0x0FFFFFF. Only bits [23:0] of each destination pixel take source data, and bits [25:24] keep their old value.
- R6: With `raw_mode` at 1, `pm_wr_mask` is all ones, and all 26 bits of each pixel are copied.
- R7: Data bits [23:20] and [63:29] are reserved and do not affect the copy.
- R8: When the destination index is greater than the source index, pixels are processed from the highest index down. An overlapping run therefore ends up equal to a copy of the source as it was before the copy started.
- R9: When the destination index is less than or equal to the source index, pixels are processed from the lowest index up, with the same snapshot-equal result.
- R10: `raw_mode` is sampled when the write is taken. A change to it during a copy has no effect on that copy.
- R11: Out of reset, `busy`, `pm_rd_en` and `pm_wr_en` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write to the copy aperture is present |
| wr_ready | output | 1 | Engine can take a write |
| wr_addr | input | 23 | Byte address within the aperture; bits [22:3] give the destination index |
| wr_data | input | 64 | Source index, run length and reserved bits |
| raw_mode | input | 1 | 1 selects a 26-bit copy, 0 selects a 24-bit copy |
| busy | output | 1 | A copy is in progress |
| pm_rd_en | output | 1 | Pixel memory read strobe |
| pm_rd_addr | output | 20 | Pixel memory read index |
| pm_rd_data | input | 26 | Read data, valid one cycle after `pm_rd_en` |
| pm_wr_en | output | 1 | Pixel memory write strobe |
| pm_wr_addr | output | 20 | Pixel memory write index |
| pm_wr_data | output | 26 | Pixel write data |
| pm_wr_mask | output | 26 | Per-bit write enable |

## Verification
A run counter or direction flag that is wrong shows at the memory port within one cycle. The result is a read index that jumps instead of stepping by one, an extra or missing write, or a busy period that is not N+1 cycles long. A reversed direction on an overlapping run has a different effect: it corrupts the destination values that the scoreboard compares, starting with the first write that lands on a source pixel not yet read. A mode latched at the wrong moment, or a mask that is wrong, shows up in the top two bits of the merged destination pixel on the first write of the copy.

// File: rtl/pixel_row_copier.sv
module pixel_row_copier #(
  parameter int PIX_W   = 26,
  parameter int LOW_W   = 24,
  parameter int ADDR_W  = 20,
  parameter int RUN_MAX = 32,
  parameter int WID_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W+2:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              raw_mode,
  output logic              busy,
  output logic              pm_rd_en,
  output logic [ADDR_W-1:0] pm_rd_addr,
  input  logic [PIX_W-1:0]  pm_rd_data,
  output logic              pm_wr_en,
  output logic [ADDR_W-1:0] pm_wr_addr,
  output logic [PIX_W-1:0]  pm_wr_data,
  output logic [PIX_W-1:0]  pm_wr_mask
);
  localparam int CNT_W = $clog2(RUN_MAX);

  logic              rd_act, wr_pend, down, raw_q;
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] src_p, dst_p, wdst;

  wire              take   = wr_valid && wr_ready;
  wire              start  = take && (wr_addr[2:0] == 3'b000);
  wire [ADDR_W-1:0] a_dst  = wr_addr[ADDR_W+2:3];
  wire [ADDR_W-1:0] a_src  = wr_data[ADDR_W-1:0];
  wire [CNT_W-1:0]  a_last = wr_data[WID_LSB +: CNT_W];
  wire              a_down = a_dst > a_src;
  wire              unused_rsvd = ^{wr_data[63:WID_LSB+CNT_W], wr_data[WID_LSB-1:ADDR_W]};

  assign busy     = rd_act | wr_pend;
  assign wr_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act  <= 1'b0;
      wr_pend <= 1'b0;
      down    <= 1'b0;
      raw_q   <= 1'b0;
      left    <= '0;
      src_p   <= '0;
      dst_p   <= '0;
      wdst    <= '0;
    end else begin
      wr_pend <= rd_act;
      wdst    <= dst_p;
      if (start) begin
        rd_act <= 1'b1;
        left   <= a_last;
        down   <= a_down;
        raw_q  <= raw_mode;
        src_p  <= a_down ? a_src + ADDR_W'(a_last) : a_src;
        dst_p  <= a_down ? a_dst + ADDR_W'(a_last) : a_dst;
      end else if (rd_act) begin
        left  <= left - 1'b1;
        src_p <= down ? src_p - 1'b1 : src_p + 1'b1;
        dst_p <= down ? dst_p - 1'b1 : dst_p + 1'b1;
        if (left == '0) rd_act <= 1'b0;
      end
    end
  end

  assign pm_rd_en   = rd_act;
  assign pm_rd_addr = src_p;
  assign pm_wr_en   = wr_pend;
  assign pm_wr_addr = wdst;
  assign pm_wr_data = pm_rd_data;
  assign pm_wr_mask = raw_q ? {PIX_W{1'b1}} : {{(PIX_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
endmodule

// File: rtl/pixel_row_copier_chk.sv
module pixel_row_copier_chk #(
  parameter int PIX_W   = 26,
  parameter int LOW_W   = 24,
  parameter int ADDR_W  = 20,
  parameter int RUN_MAX = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              busy,
  input logic              pm_rd_en,
  input logic [ADDR_W-1:0] pm_rd_addr,
  input logic              pm_wr_en,
  input logic [PIX_W-1:0]  pm_wr_mask
);
  localparam int RUN_W = $clog2(RUN_MAX) + 2;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= pm_rd_en ? run + 1'b1 : '0;
  end

  assert_busy_from_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_valid && wr_ready));

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_wr_en |-> $past(pm_rd_en));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rd_en && $past(pm_rd_en)) |->
      ((pm_rd_addr - $past(pm_rd_addr)) == ADDR_W'(1) ||
       ($past(pm_rd_addr) - pm_rd_addr) == ADDR_W'(1)));

  assert_low_bits_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_wr_en |-> (&pm_wr_mask[LOW_W-1:0]));

  assert_run_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |-> (run < RUN_W'(RUN_MAX)));
endmodule

bind pixel_row_copier pixel_row_copier_chk #(
  .PIX_W(PIX_W), .LOW_W(LOW_W), .ADDR_W(ADDR_W), .RUN_MAX(RUN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .busy(busy), .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr),
  .pm_wr_en(pm_wr_en), .pm_wr_mask(pm_wr_mask)
);

// File: tb/test_pixel_row_copier.sv
module test_pixel_row_copier;
  localparam int MW = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready, raw_mode, busy;
  logic [22:0] wr_addr;
  logic [63:0] wr_data;
  logic        pm_rd_en, pm_wr_en;
  logic [19:0] pm_rd_addr, pm_wr_addr;
  logic [25:0] pm_rd_data, pm_wr_data, pm_wr_mask;

  always #5 clk = ~clk;

  pixel_row_copier i_pixel_row_copier (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .raw_mode(raw_mode), .busy(busy),
    .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr), .pm_rd_data(pm_rd_data),
    .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr), .pm_wr_data(pm_wr_data),
    .pm_wr_mask(pm_wr_mask)
  );

  function automatic logic [25:0] pat(input int i);
    return 26'((i * 32'h9E3779B1) ^ (i << 13));
  endfunction

  logic [25:0] mem [MW];
  logic [25:0] ref_mem [MW];
  logic [25:0] rd_q;
  assign pm_rd_data = rd_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem[i] <= pat(i);
      rd_q <= '0;
    end else begin
      if (pm_rd_en) rd_q <= mem[pm_rd_addr[11:0]];
      if (pm_wr_en)
        mem[pm_wr_addr[11:0]] <= (mem[pm_wr_addr[11:0]] & ~pm_wr_mask) | (pm_wr_data & pm_wr_mask);
    end
  end

  typedef struct packed { logic [19:0] a; logic [25:0] v; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int    mon_chk = 0, mon_fail = 0;

  always @(negedge clk) begin : monitor
    logic [25:0] merged;
    item_t e;
    string t;
    if (rst_n === 1'b1 && pm_wr_en) begin
      merged = (mem[pm_wr_addr[11:0]] & ~pm_wr_mask) | (pm_wr_data & pm_wr_mask);
      mon_chk++;
      if (exp_q.size() == 0) begin
        mon_fail++;
        $display("FAIL R4 unexpected write actual=%0h:%0h expected=none", pm_wr_addr, merged);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({pm_wr_addr, merged} !== e) begin
          mon_fail++;
          $display("FAIL %s write actual=%0h:%0h expected=%0h:%0h", t, pm_wr_addr, merged, e.a, e.v);
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_copy(input int dst, input int src, input int last, input bit raw, input string tag);
    logic [25:0] snap [32];
    bit down;
    int i;
    logic [25:0] v;
    down = dst > src;
    for (int k = 0; k <= last; k++) snap[k] = ref_mem[src + k];
    for (int k = 0; k <= last; k++) begin
      i = down ? last - k : k;
      v = raw ? snap[i] : {ref_mem[dst + i][25:24], snap[i][23:0]};
      ref_mem[dst + i] = v;
      exp_q.push_back({20'(dst + i), v});
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [22:0] a, input logic [63:0] d, input bit raw, output int waits);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; raw_mode = raw;
    waits = 0;
    while (!wr_ready) begin waits++; @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    raw_mode = !raw;
  endtask

  function automatic logic [63:0] mk(input int src, input int last, input logic [34:0] jhi, input logic [3:0] jmid);
    return {jhi, 5'(last), jmid, 20'(src)};
  endfunction

  task automatic region(input int base, input string req);
    bit ok = 1'b1;
    longint act = 0, exp = 0;
    for (int i = 0; i < 40; i++)
      if (ok && mem[base + i] !== ref_mem[base + i]) begin
        ok = 1'b0; act = mem[base + i]; exp = ref_mem[base + i];
      end
    chk(ok, req, act, exp);
  endtask

  task automatic drain(input int want, input string req);
    int cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == want, req, cnt, want);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic copy(input int dst, input int src, input int last, input bit raw,
                      input logic [34:0] jhi, input logic [3:0] jmid, input string tag);
    int w;
    expect_copy(dst, src, last, raw, tag);
    send(23'(dst << 3), mk(src, last, jhi, jmid), raw, w);
    drain(last + 2, {tag, " R4 busy cycles"});
    region(dst < src ? dst : src, {tag, " region"});
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", (n_chk + mon_chk) - (n_fail + mon_fail), n_chk + mon_chk);
  endtask

  initial begin
    int w;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; raw_mode = 1'b0;
    for (int i = 0; i < MW; i++) ref_mem[i] = pat(i);
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0 && wr_ready == 1'b1, "R11 busy/ready", {busy, wr_ready}, 2'b01);
        chk(pm_rd_en == 1'b0 && pm_wr_en == 1'b0, "R11 strobes", {pm_rd_en, pm_wr_en}, 0);

        copy(1200, 100, 7, 1'b0, '0, '0, "R2 R5 basic");
        copy(1500, 300, 31, 1'b1, '0, '0, "R6 raw full run");
        copy(700, 650, 0, 1'b0, '0, '0, "R2 single pixel");
        copy(2001, 37, 12, 1'b1, '0, '0, "R2 unaligned start");
        copy(803, 800, 19, 1'b1, '0, '0, "R8 overlap right");
        copy(803, 800, 19, 1'b0, '0, '0, "R8 overlap right 24b");
        copy(895, 900, 31, 1'b1, '0, '0, "R9 overlap left");
        copy(1000, 1000, 3, 1'b0, '0, '0, "R9 same place");
        copy(2500, 2600, 15, 1'b0, 35'h5_A5A5_A5A5, 4'hF, "R7 reserved bits");
        copy(3000, 3100, 9, 1'b0, '0, '0, "R10 mode flip 24b");
        copy(3200, 3300, 9, 1'b1, '0, '0, "R10 mode flip raw");

        // R3 misaligned write: taken, no copy
        send(23'((3500 << 3) | 4), mk(3400, 5, '0, '0), 1'b1, w);
        chk(w == 0, "R3 taken at once", w, 0);
        drain(0, "R3 no busy");
        region(3500, "R3 memory untouched");

        // R1 stall of a second write
        expect_copy(3700, 3600, 7, 1'b0, "R1 first");
        expect_copy(3800, 3700, 4, 1'b1, "R1 second");
        send(23'(3700 << 3), mk(3600, 7, '0, '0), 1'b0, w);
        send(23'(3800 << 3), mk(3700, 4, '0, '0), 1'b1, w);
        chk(w == 8, "R1 stalled cycles", w, 8);
        drain(6, "R1 second copy");
        region(3700, "R1 first region");
        region(3800, "R1 second region");
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule